// File: doc/BRIEF.md
# Shift-Register-Sequenced FIFO with Identity-Compare Flags

A single-clock first-in first-out buffer whose read and write addresses step through a maximal-length linear-feedback shift sequence rather than a binary count. A pointer's successor is its current value moved one place with a feedback bit inserted. Its predecessor is one reverse shift. Empty and full come only from equality tests between one pointer and the successor or predecessor of the other pointer. No subtraction is used anywhere in the pointer path.

With the default 4-bit pointers the sequence visits 15 non-zero states, so the buffer holds 15 words. Both pointers start from the same non-zero seed. A half-full indication comes from a small up/down occupancy counter, because shift-sequence addresses carry no magnitude. Requests that cannot be honoured are dropped without side effects. Read data is registered.

Top module: `lfsr_fifo`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, half_o is 0 and rd_data_o is 0.
- R2: Words are read out in the order they were written. An accepted read puts its word on rd_data_o at the next rising clock edge, and rd_data_o holds its value in every cycle without an accepted read.
- R3: The buffer holds exactly 2^PTR_W-1 words (15 by default). full_o is 0 after 14 writes from empty and 1 after the 15th.
- R4: A write request while full_o is 1 and no read is accepted is dropped. full_o stays 1, and the dropped word never appears at the read side.
- R5: A read request while empty_o is 1 is dropped. empty_o stays 1 and rd_data_o keeps its previous value.
- R6: Any accepted write clears empty_o on the next edge. empty_o is set when a read-only cycle takes the last stored word.
- R7: Any accepted read clears full_o on the next edge.
- R8: half_o is 1 exactly when the number of stored words is at least HALF_LVL (8 by default).
- R9: A cycle with both requests while neither empty nor full moves both pointers and leaves empty_o, full_o and half_o unchanged. With both requests while empty, only the write takes effect.
- R10: Order is kept across pointer wrap-around, through many more transfers than the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| rd_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read word |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | All 15 locations hold words |
| half_o | output | 1 | Occupancy at or above HALF_LVL |

## Verification
The bench fills to exactly 14 and then 15 words. A one-off error in the predecessor comparison would raise full one word early, or let a 16th write overwrite the oldest word. It then pushes a write against a full buffer and drains everything. A design that did not drop that write would return the extra word or lose ordering. Reads against an empty buffer, and combined requests while empty, check that a drop moves neither rd_data_o nor the read pointer; a leaking pointer would return stale data later. A long run of combined requests at the half-full point checks that the flags stay put and that order survives many wraps.

// File: rtl/lfsr_fifo_pkg.sv
package lfsr_fifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_BOTH = 2'd3
  } fifo_op_e;
endpackage

// File: rtl/lfsr_step.sv
// One shift of the sequence; REVERSE picks predecessor instead of successor.
module lfsr_step #(
  parameter int unsigned W       = 4,
  parameter int unsigned TAP     = 2,
  parameter bit          REVERSE = 1'b0
) (
  input  logic [W-1:0] s_i,
  output logic [W-1:0] s_o
);
  generate
    if (!REVERSE) begin : g_fwd
      assign s_o = {s_i[W-2:0], s_i[W-1] ^ s_i[TAP]};
    end else begin : g_rev
      assign s_o = {s_i[0] ^ s_i[TAP+1], s_i[W-1:1]};
    end
  endgenerate
endmodule

// File: rtl/lfsr_ptr.sv
module lfsr_ptr #(
  parameter int unsigned W    = 4,
  parameter int unsigned TAP  = 2,
  parameter int unsigned SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] nxt;

  lfsr_step #(.W(W), .TAP(TAP), .REVERSE(1'b0)) u_step (
    .s_i (ptr_o),
    .s_o (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= W'(SEED);
    else if (adv_i) ptr_o <= nxt;
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned W      = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [W-1:0]      waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [W-1:0]      raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned ENTRIES = 1 << W;

  logic [DATA_W-1:0] mem [ENTRIES];

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk_i) begin
        if (we_i && waddr_i == W'(i)) mem[i] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
  import lfsr_fifo_pkg::*;
#(
  parameter int unsigned W        = 4,
  parameter int unsigned TAP      = 2,
  parameter int unsigned HALF_LVL = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  fifo_op_e     op_i,
  input  logic [W-1:0] rd_ptr_i,
  input  logic [W-1:0] wr_ptr_i,
  output logic         empty_o,
  output logic         full_o,
  output logic         half_o
);
  localparam logic [W-1:0] HALF_C = W'(HALF_LVL);

  logic [W-1:0] rd_next, rd_prev, occ;

  lfsr_step #(.W(W), .TAP(TAP), .REVERSE(1'b0)) u_rd_next (
    .s_i (rd_ptr_i),
    .s_o (rd_next)
  );
  lfsr_step #(.W(W), .TAP(TAP), .REVERSE(1'b1)) u_rd_prev (
    .s_i (rd_ptr_i),
    .s_o (rd_prev)
  );

  // Full: writer sits one step behind reader. Empty: reader's successor meets writer.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      full_o  <= 1'b0;
      occ     <= '0;
    end else begin
      unique case (op_i)
        OP_WR: begin
          empty_o <= 1'b0;
          occ     <= occ + 1'b1;
          if (wr_ptr_i == rd_prev) full_o <= 1'b1;
        end
        OP_RD: begin
          full_o <= 1'b0;
          occ    <= occ - 1'b1;
          if (rd_next == wr_ptr_i) empty_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign half_o = (occ >= HALF_C);
endmodule

// File: rtl/lfsr_fifo.sv
module lfsr_fifo
  import lfsr_fifo_pkg::*;
#(
  parameter int unsigned PTR_W    = 4,
  parameter int unsigned TAP      = 2,
  parameter int unsigned SEED     = 1,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_LVL = 1 << (PTR_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o
);
  logic           wr_acc, rd_acc;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  fifo_op_e       op;

  assign wr_acc = wr_i & ~full_o;
  assign rd_acc = rd_i & ~empty_o;

  always_comb begin
    unique case ({rd_acc, wr_acc})
      2'b01:   op = OP_WR;
      2'b10:   op = OP_RD;
      2'b11:   op = OP_BOTH;
      default: op = OP_IDLE;
    endcase
  end

  lfsr_ptr #(.W(PTR_W), .TAP(TAP), .SEED(SEED)) u_wr_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (wr_acc),
    .ptr_o  (wr_ptr)
  );

  lfsr_ptr #(.W(PTR_W), .TAP(TAP), .SEED(SEED)) u_rd_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (rd_acc),
    .ptr_o  (rd_ptr)
  );

  fifo_store #(.W(PTR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_acc),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .re_i    (rd_acc),
    .raddr_i (rd_ptr),
    .rdata_o (rd_data_o)
  );

  fifo_flags #(.W(PTR_W), .TAP(TAP), .HALF_LVL(HALF_LVL)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .rd_ptr_i (rd_ptr),
    .wr_ptr_i (wr_ptr),
    .empty_o  (empty_o),
    .full_o   (full_o),
    .half_o   (half_o)
  );
endmodule

// File: rtl/lfsr_fifo_chk.sv
module lfsr_fifo_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              half_o
);
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R3

  AST_FULL_DROPS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !rd_i |=> full_o); // R4

  AST_EMPTY_DROPS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i && !wr_i |=> empty_o && $stable(rd_data_o)); // R5

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !full_o |=> !empty_o); // R6

  AST_RD_CLEARS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !empty_o |=> !full_o); // R7

  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o); // R8

  AST_BOTH_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && rd_i && !empty_o && !full_o |=>
      $stable(empty_o) && $stable(full_o) && $stable(half_o)); // R9

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !empty_o) |=> $stable(rd_data_o)); // R2
endmodule

bind lfsr_fifo lfsr_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .empty_o   (empty_o),
  .full_o    (full_o),
  .half_o    (half_o)
);

// File: tb/lfsr_fifo_test.sv
`timescale 1ns/1ps
module lfsr_fifo_test;
  localparam int DEPTH = 15;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       empty_o, full_o, half_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [$];
  logic [7:0] last_rd = 8'h00;

  always #2 clk_i = ~clk_i;

  lfsr_fifo uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
    .full_o(full_o), .half_o(half_o)
  );

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] d;
    logic       e;
    logic       f;
    logic       h;
    logic [7:0] q;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{1'b1, 1'b0, 8'hB2, 1'b0, 1'b0, 1'b0, 8'h00},
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA1},
    '{1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 8'hB2},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC3},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC3},
    '{1'b1, 1'b1, 8'hD4, 1'b0, 1'b0, 1'b0, 8'hC3},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'hD4}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle; inputs change at negedge, outputs sampled 1 ns after posedge.
  task automatic step(input logic w, input logic r, input logic [7:0] d);
    logic w_ok, r_ok;
    @(negedge clk_i);
    wr_i = w; rd_i = r; wr_data_i = d;
    r_ok = r && (model.size() > 0);
    w_ok = w && (model.size() < DEPTH);
    @(posedge clk_i);
    #1;
    if (r_ok) last_rd = model.pop_front();
    if (w_ok) model.push_back(d);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " empty R6"}, {7'd0, empty_o}, {7'd0, model.size() == 0});
    chk({tag, " full R3"},  {7'd0, full_o},  {7'd0, model.size() == DEPTH});
    chk({tag, " half R8"},  {7'd0, half_o},  {7'd0, model.size() >= 8});
    chk({tag, " data R2"},  rd_data_o, last_rd);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 empty", {7'd0, empty_o}, 8'd1);
    chk("R1 full",  {7'd0, full_o},  8'd0);
    chk("R1 half",  {7'd0, half_o},  8'd0);
    chk("R1 data",  rd_data_o, 8'h00);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      step(VECS[i].wr, VECS[i].rd, VECS[i].d);
      chk($sformatf("R6 vec%0d empty", i), {7'd0, empty_o}, {7'd0, VECS[i].e});
      chk($sformatf("R7 vec%0d full", i),  {7'd0, full_o},  {7'd0, VECS[i].f});
      chk($sformatf("R8 vec%0d half", i),  {7'd0, half_o},  {7'd0, VECS[i].h});
      chk($sformatf("R2 vec%0d data", i),  rd_data_o, VECS[i].q);
    end
    last_rd = 8'hD4;

    // Fill to capacity: half at 8, full only at 15 (R3, R8)
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 8'(8'h10 + i));
      chk_model($sformatf("fill%0d", i));
    end
    // Dropped write while full (R4)
    step(1'b1, 1'b0, 8'hEE);
    chk("R4 full kept", {7'd0, full_o}, 8'd1);
    chk_model("R4 after drop");
    // One read clears full (R7)
    step(1'b0, 1'b1, 8'h00);
    chk("R7 full cleared", {7'd0, full_o}, 8'd0);
    chk_model("R7 after read");
    step(1'b1, 1'b0, 8'h5A);
    chk_model("R10 refill");
    // Drain all; the dropped 0xEE must not appear (R4, R10)
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 1'b1, 8'h00);
      chk_model($sformatf("R10 drain%0d", i));
      if (rd_data_o == 8'hEE) chk("R4 dropped word seen", rd_data_o, 8'h00);
    end
    // Reads while empty are dropped (R5)
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 8'h00);
      chk("R5 empty kept", {7'd0, empty_o}, 8'd1);
      chk("R5 data held", rd_data_o, last_rd);
    end
    // Both requests while empty: write only (R9)
    step(1'b1, 1'b1, 8'h77);
    chk("R9 empty both", {7'd0, empty_o}, 8'd0);
    chk_model("R9 empty both");
    // Bring to 8 words and stream with both requests (R9, R10)
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 8'(8'h30 + i));
    chk("R8 at eight", {7'd0, half_o}, 8'd1);
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b1, 8'(8'h80 + i));
      chk($sformatf("R9 stream%0d half", i), {7'd0, half_o}, 8'd1);
      chk_model($sformatf("R9 stream%0d", i));
    end
    // Drop to seven: half clears (R8)
    step(1'b0, 1'b1, 8'h00);
    chk("R8 at seven", {7'd0, half_o}, 8'd0);
    chk_model("R8 seven");

    // Reset mid-run (R1)
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 re-reset empty", {7'd0, empty_o}, 8'd1);
    chk("R1 re-reset half",  {7'd0, half_o},  8'd0);
    chk("R1 re-reset data",  rd_data_o, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule